// File: doc/BRIEF.md
# Local Interrupt Priority and Acknowledge Unit

This block sits beside one processor and decides which pending interrupt it may take. Requests arrive as a vector number plus a trigger kind. The block keeps three bit vectors with one bit per vector:

- pending requests,
- vectors currently being serviced,
- the trigger kind of each vector.

From a software-set task priority and the highest vector in service, it derives a processor priority. It raises a request line whenever a pending vector belongs to a strictly higher 16-vector class than that priority.

The processor answers the request line with an acknowledge strobe. One cycle later it gets back either the winning vector, which moves from pending to in-service, or the spurious vector when nothing can be delivered. An end-of-interrupt strobe retires the highest in-service vector. A small register port gives access to the task priority, the spurious/enable register and the derived priority, and read-only access to the three vectors one 32-bit word at a time.

Top module: `intr_accept_unit`

## Requirements
- R1: The selected pending or in-service vector is always the highest-numbered set bit of its bit vector. An empty vector is reported as "none".
- R2: The processor priority (PPR, read at index 0x0A) equals TPR when TPR[7:4] is at least the class (bits 7:4) of the highest in-service vector. An empty in-service vector counts as class 0. Otherwise PPR equals that class shifted left by 4 with a zero low nibble.
- R3: `irq_req` is high exactly when all three of these hold:
  - spurious/enable register bit 8 is 1;
  - some request bit is pending;
  - PPR is zero, or the class of the highest pending vector is greater than PPR[7:4].

  It is combinational from the stored state, so it reflects a state change in the cycle after the clock edge that made it.
- R4: A cycle with `set_valid` high sets the pending bit of `set_vector` and writes its trigger bit: 1 when `set_level` is high, 0 when it is low. A set wins over an acknowledge that clears the same pending bit in the same cycle.
- R5: An accepted `ack_req` moves the highest pending vector from pending to in-service. The cycle after, `ack_done` is high for one cycle and `ack_vector` carries that vector.
- R6: When TPR is non-zero and the highest pending vector is numerically at or below TPR, an acknowledge returns the spurious/enable register bits 7:0 and leaves all vectors unchanged.
- R7: An acknowledge with nothing pending returns the spurious/enable register bits 7:0 and changes no state.
- R8: `eoi` clears the highest in-service bit, judged on the state before any same-cycle acknowledge. It has no effect when nothing is in service.
- R9: The spurious/enable register (index 0x0F) resets to 0x0FF. A write keeps only the low 9 bits. A read returns it zero-extended.
- R10: The register port decodes these indices:
  - TPR at index 0x08: 8 bits, resets to 0, readable and writable.
  - In-service words at 0x10+w, trigger words at 0x18+w, pending words at 0x20+w: bit b of word w is vector 32*w+b.
  - PPR and the three vector words are read-only; writes to them are ignored.
  - Any other index reads 0.
- R11: After reset all three vectors are empty, and `irq_req` and `ack_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_valid | input | 1 | Post a request this cycle |
| set_vector | input | VEC_W | Vector to post |
| set_level | input | 1 | 1 = level trigger, 0 = edge |
| irq_req | output | 1 | Request to the processor |
| ack_req | input | 1 | Acknowledge strobe from the processor |
| ack_done | output | 1 | Acknowledge answer valid |
| ack_vector | output | VEC_W | Vector returned by the acknowledge |
| eoi | input | 1 | End-of-interrupt strobe |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |

## Verification
The bench builds the block with its defaults: 8-bit vectors, a 16-vector class and 32-bit words. All 256 vectors, all eight words of each bit vector and the two-level scan variant are therefore exercised, including vectors 0 and 255 and the class boundaries. Random TPR values, many of them zero, together with random enable-bit patterns push acknowledges through the accepted, blocked and empty paths. Overlapping set, acknowledge and end-of-interrupt strobes cover the same-cycle ordering rules.

// File: rtl/iau_pkg.sv
package iau_pkg;
   localparam logic [7:0] IDX_TPR      = 8'h08;
   localparam logic [7:0] IDX_PPR      = 8'h0A;
   localparam logic [7:0] IDX_SVR      = 8'h0F;
   localparam logic [7:0] IDX_ISR_BASE = 8'h10;
   localparam logic [7:0] IDX_TMR_BASE = 8'h18;
   localparam logic [7:0] IDX_IRR_BASE = 8'h20;
endpackage

// File: rtl/iau_top_scan.sv
module iau_top_scan #(
   parameter int NBITS = 256,
   parameter int SEG_W = 32
) (
   input  logic [NBITS-1:0]         bits_i,
   output logic                     any_o,
   output logic [$clog2(NBITS)-1:0] idx_o
);
   localparam int IDX_W = $clog2(NBITS);

   initial begin
      assert (NBITS == (1 << IDX_W)) else $error("NBITS must be a power of two");
   end

   assign any_o = |bits_i;

   generate
      if (NBITS > SEG_W) begin : g_two
         localparam int NSEG   = NBITS / SEG_W;
         localparam int SEG_IW = $clog2(SEG_W);
         localparam int SEG_NW = $clog2(NSEG);
         logic [NSEG-1:0]   seg_any;
         logic [SEG_IW-1:0] seg_idx [NSEG];
         logic [SEG_NW-1:0] top_seg;
         logic [SEG_IW-1:0] top_lo;

         for (genvar s = 0; s < NSEG; s++) begin : g_seg
            logic [SEG_IW-1:0] loc;
            always_comb begin
               loc = '0;
               for (int b = 0; b < SEG_W; b++)
                  if (bits_i[s*SEG_W+b]) loc = SEG_IW'(b);
            end
            assign seg_any[s] = |bits_i[s*SEG_W +: SEG_W];
            assign seg_idx[s] = loc;
         end

         always_comb begin
            top_seg = '0;
            top_lo  = seg_idx[0];
            for (int s = 0; s < NSEG; s++)
               if (seg_any[s]) begin
                  top_seg = SEG_NW'(s);
                  top_lo  = seg_idx[s];
               end
         end
         assign idx_o = {top_seg, top_lo};
      end else begin : g_flat
         always_comb begin
            idx_o = '0;
            for (int b = 0; b < NBITS; b++)
               if (bits_i[b]) idx_o = IDX_W'(b);
         end
      end
   endgenerate
endmodule

// File: rtl/iau_prio.sv
module iau_prio #(
   parameter int VEC_W   = 8,
   parameter int CLS_LSB = 4
) (
   input  logic             sw_en,
   input  logic [VEC_W-1:0] tpr,
   input  logic             isr_any,
   input  logic [VEC_W-CLS_LSB-1:0] isr_cls,
   input  logic             irr_any,
   input  logic [VEC_W-CLS_LSB-1:0] irr_cls,
   output logic [VEC_W-1:0] ppr,
   output logic             req
);
   localparam int CLS_W = VEC_W - CLS_LSB;

   logic [CLS_W-1:0] svc_cls;
   logic [CLS_W-1:0] tpr_cls;

   assign svc_cls = isr_any ? isr_cls : '0;
   assign tpr_cls = tpr[VEC_W-1:CLS_LSB];
   assign ppr     = (tpr_cls >= svc_cls) ? tpr : {svc_cls, {CLS_LSB{1'b0}}};
   assign req     = sw_en && irr_any &&
                    ((ppr == '0) || (irr_cls > ppr[VEC_W-1:CLS_LSB]));
endmodule

// File: rtl/intr_accept_unit.sv
module intr_accept_unit
   import iau_pkg::*;
#(
   parameter int VEC_W   = 8,
   parameter int CLS_LSB = 4,
   parameter int WORD_W  = 32,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_valid,
   input  logic [VEC_W-1:0]  set_vector,
   input  logic              set_level,
   output logic              irq_req,
   input  logic              ack_req,
   output logic              ack_done,
   output logic [VEC_W-1:0]  ack_vector,
   input  logic              eoi,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata
);
   localparam int NVEC   = 1 << VEC_W;
   localparam int NWORDS = NVEC / WORD_W;
   localparam int SVR_W  = VEC_W + 1;
   localparam logic [SVR_W-1:0] SVR_RST = SVR_W'((1 << VEC_W) - 1);

   initial begin
      assert (VEC_W >= 6 && VEC_W <= 8) else $error("VEC_W out of range");
      assert (CLS_LSB > 0 && CLS_LSB < VEC_W) else $error("bad CLS_LSB");
      assert (NVEC % WORD_W == 0) else $error("WORD_W must divide vector count");
      assert (DATA_W >= WORD_W && DATA_W > SVR_W) else $error("DATA_W too small");
      assert (ADDR_W >= 8) else $error("ADDR_W too small");
   end

   logic [NVEC-1:0]  irr, isr, tmr;
   logic [NVEC-1:0]  irr_n, isr_n, tmr_n;
   logic [VEC_W-1:0] tpr;
   logic [SVR_W-1:0] svr;
   logic             irr_any, isr_any;
   logic [VEC_W-1:0] irr_hi, isr_hi;
   logic [VEC_W-1:0] ppr;
   logic             ack_take;
   logic [VEC_W-1:0] ack_sel;
   logic             wdata_unused;

   assign wdata_unused = ^reg_wdata[DATA_W-1:SVR_W];

   iau_top_scan #(.NBITS(NVEC), .SEG_W(WORD_W)) u_irr_scan (
      .bits_i(irr), .any_o(irr_any), .idx_o(irr_hi));
   iau_top_scan #(.NBITS(NVEC), .SEG_W(WORD_W)) u_isr_scan (
      .bits_i(isr), .any_o(isr_any), .idx_o(isr_hi));

   iau_prio #(.VEC_W(VEC_W), .CLS_LSB(CLS_LSB)) u_prio (
      .sw_en   (svr[VEC_W]),
      .tpr     (tpr),
      .isr_any (isr_any),
      .isr_cls (isr_hi[VEC_W-1:CLS_LSB]),
      .irr_any (irr_any),
      .irr_cls (irr_hi[VEC_W-1:CLS_LSB]),
      .ppr     (ppr),
      .req     (irq_req));

   assign ack_take = irr_any && !((tpr != '0) && (irr_hi <= tpr));
   assign ack_sel  = ack_take ? irr_hi : svr[VEC_W-1:0];

   always_comb begin
      irr_n = irr;
      isr_n = isr;
      tmr_n = tmr;
      if (eoi && isr_any) isr_n[isr_hi] = 1'b0;
      if (ack_req && ack_take) begin
         irr_n[irr_hi] = 1'b0;
         isr_n[irr_hi] = 1'b1;
      end
      if (set_valid) begin
         irr_n[set_vector] = 1'b1;
         tmr_n[set_vector] = set_level;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr        <= '0;
         isr        <= '0;
         tmr        <= '0;
         tpr        <= '0;
         svr        <= SVR_RST;
         ack_done   <= 1'b0;
         ack_vector <= '0;
      end else begin
         irr      <= irr_n;
         isr      <= isr_n;
         tmr      <= tmr_n;
         ack_done <= ack_req;
         if (ack_req) ack_vector <= ack_sel;
         if (reg_we && reg_addr == ADDR_W'(IDX_TPR)) tpr <= reg_wdata[VEC_W-1:0];
         if (reg_we && reg_addr == ADDR_W'(IDX_SVR)) svr <= reg_wdata[SVR_W-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(IDX_TPR)) reg_rdata = DATA_W'(tpr);
      if (reg_addr == ADDR_W'(IDX_PPR)) reg_rdata = DATA_W'(ppr);
      if (reg_addr == ADDR_W'(IDX_SVR)) reg_rdata = DATA_W'(svr);
      for (int w = 0; w < NWORDS; w++) begin
         if (reg_addr == ADDR_W'(IDX_ISR_BASE) + ADDR_W'(w))
            reg_rdata = DATA_W'(isr[w*WORD_W +: WORD_W]);
         if (reg_addr == ADDR_W'(IDX_TMR_BASE) + ADDR_W'(w))
            reg_rdata = DATA_W'(tmr[w*WORD_W +: WORD_W]);
         if (reg_addr == ADDR_W'(IDX_IRR_BASE) + ADDR_W'(w))
            reg_rdata = DATA_W'(irr[w*WORD_W +: WORD_W]);
      end
   end
endmodule

// File: rtl/intr_accept_chk.sv
module intr_accept_chk
   import iau_pkg::*;
#(
   parameter int VEC_W  = 8,
   parameter int WORD_W = 32,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              set_valid,
   input logic [VEC_W-1:0]  set_vector,
   input logic              set_level,
   input logic              irq_req,
   input logic              ack_req,
   input logic [VEC_W-1:0]  ack_vector,
   input logic              eoi,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [(1<<VEC_W)-1:0] irr,
   input logic [(1<<VEC_W)-1:0] isr,
   input logic [(1<<VEC_W)-1:0] tmr,
   input logic [VEC_W:0]    svr,
   input logic [VEC_W-1:0]  tpr,
   input logic              irr_any,
   input logic [VEC_W-1:0]  irr_hi,
   input logic              isr_any,
   input logic [VEC_W-1:0]  isr_hi
);
   localparam int NWORDS = (1 << VEC_W) / WORD_W;

   logic blocked;
   logic isr_word_wr;
   assign blocked     = (tpr != '0) && (irr_hi <= tpr);
   assign isr_word_wr = reg_we && (reg_addr >= ADDR_W'(IDX_ISR_BASE)) &&
                        (reg_addr < ADDR_W'(IDX_ISR_BASE) + ADDR_W'(NWORDS));

   p_req_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (svr[VEC_W] && irr_any));

   p_set_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_valid |=> (irr[$past(set_vector)] && tmr[$past(set_vector)] == $past(set_level)));

   p_ack_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && irr_any && !blocked) |=> (isr[$past(irr_hi)] && ack_vector == $past(irr_hi)));

   p_ack_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && irr_any && blocked && !set_valid) |=>
         (ack_vector == $past(svr[VEC_W-1:0]) && irr == $past(irr)));

   p_ack_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && !irr_any) |=> (ack_vector == $past(svr[VEC_W-1:0])));

   p_eoi_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && isr_any && !ack_req) |=> !isr[$past(isr_hi)]);

   p_svr_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(IDX_SVR)) |=> (svr == $past(reg_wdata[VEC_W:0])));

   p_ro_words_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (isr_word_wr && !ack_req && !eoi) |=> $stable(isr));
endmodule

bind intr_accept_unit intr_accept_chk #(
   .VEC_W(VEC_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_vector(set_vector),
   .set_level(set_level), .irq_req(irq_req), .ack_req(ack_req),
   .ack_vector(ack_vector), .eoi(eoi), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .irr(irr), .isr(isr), .tmr(tmr), .svr(svr), .tpr(tpr),
   .irr_any(irr_any), .irr_hi(irr_hi), .isr_any(isr_any), .isr_hi(isr_hi)
);

// File: tb/test_intr_accept_unit.sv
module test_intr_accept_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        set_valid = 1'b0;
   logic [7:0]  set_vector = '0;
   logic        set_level = 1'b0;
   logic        irq_req;
   logic        ack_req = 1'b0;
   logic        ack_done;
   logic [7:0]  ack_vector;
   logic        eoi = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
   logic [7:0]   m_tpr = '0;
   logic [8:0]   m_svr = 9'h0FF;

   always #10 clk = ~clk;

   intr_accept_unit i_intr_accept_unit (
      .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_vector(set_vector),
      .set_level(set_level), .irq_req(irq_req), .ack_req(ack_req),
      .ack_done(ack_done), .ack_vector(ack_vector), .eoi(eoi), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

   function automatic int hi_of(input logic [255:0] v);
      for (int i = 255; i >= 0; i--) if (v[i]) return i;
      return -1;
   endfunction

   function automatic logic [7:0] m_ppr();
      int h = hi_of(m_isr);
      int icls = (h < 0) ? 0 : (h >> 4);
      if (int'(m_tpr[7:4]) >= icls) return m_tpr;
      return 8'(icls << 4);
   endfunction

   function automatic logic m_req();
      int h = hi_of(m_irr);
      logic [7:0] p = m_ppr();
      if (!m_svr[8] || h < 0) return 1'b0;
      return (p == 8'd0) || ((h >> 4) > int'(p[7:4]));
   endfunction

   function automatic logic [31:0] m_read(input logic [7:0] a);
      if (a == 8'h08) return 32'(m_tpr);
      if (a == 8'h0A) return 32'(m_ppr());
      if (a == 8'h0F) return 32'(m_svr);
      if (a >= 8'h10 && a <= 8'h17) return m_isr[(a - 8'h10)*32 +: 32];
      if (a >= 8'h18 && a <= 8'h1F) return m_tmr[(a - 8'h18)*32 +: 32];
      if (a >= 8'h20 && a <= 8'h27) return m_irr[(a - 8'h20)*32 +: 32];
      return 32'd0;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic read_one(input logic [7:0] a);
      string tag;
      reg_addr = a;
      #1;
      if (a >= 8'h10 && a <= 8'h17) tag = "R8 in-service word";
      else if (a >= 8'h18 && a <= 8'h27) tag = "R4 trigger/pending word";
      else if (a == 8'h0A) tag = "R2 ppr";
      else if (a == 8'h0F) tag = "R9 svr";
      else tag = "R10 tpr/unused index";
      check(tag, reg_rdata, m_read(a));
   endtask

   task automatic read_all();
      read_one(8'h08); read_one(8'h0A); read_one(8'h0F);
      for (int a = 8'h10; a <= 8'h27; a++) read_one(8'(a));
      read_one(8'h00); read_one(8'h09); read_one(8'h28); read_one(8'hFF);
   endtask

   // Called at a falling edge; applies one clock of stimulus and checks outputs.
   task automatic step(input logic sv, input logic [7:0] vec, input logic lvl,
                       input logic ak, input logic eo, input logic we,
                       input logic [7:0] addr, input logic [31:0] wd);
      int h;
      logic [7:0] exp_vec;
      string ack_tag;
      set_valid = sv; set_vector = vec; set_level = lvl;
      ack_req = ak; eoi = eo; reg_we = we; reg_addr = addr; reg_wdata = wd;
      exp_vec = m_svr[7:0];
      ack_tag = "R7 empty ack";
      if (eo) begin
         h = hi_of(m_isr);
         if (h >= 0) m_isr[h] = 1'b0;
      end
      if (ak) begin
         h = hi_of(m_irr);
         if (h >= 0 && m_tpr != 0 && h <= int'(m_tpr)) ack_tag = "R6 blocked ack";
         else if (h >= 0) begin
            ack_tag = "R1/R5 accepted ack";
            exp_vec = 8'(h);
            m_irr[h] = 1'b0;
            m_isr[h] = 1'b1;
         end
      end
      if (sv) begin
         m_irr[vec] = 1'b1;
         m_tmr[vec] = lvl;
      end
      if (we && addr == 8'h08) m_tpr = wd[7:0];
      if (we && addr == 8'h0F) m_svr = wd[8:0];
      @(posedge clk);
      @(negedge clk);
      set_valid = 1'b0; ack_req = 1'b0; eoi = 1'b0; reg_we = 1'b0;
      check("R5 ack_done", 32'(ack_done), 32'(ak));
      if (ak) check(ack_tag, 32'(ack_vector), 32'(exp_vec));
      check("R3 irq_req", 32'(irq_req), 32'(m_req()));
   endtask

   task automatic idle(); step(0, 0, 0, 0, 0, 0, 8'h00, 0); endtask

   initial begin
      void'($urandom(32'h1A2B3C));
      repeat (3) @(negedge clk);
      check("R11 irq_req in reset", 32'(irq_req), 32'd0);
      check("R11 ack_done in reset", 32'(ack_done), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      read_all();
      // directed corner cases
      step(0, 0, 0, 1, 0, 0, 8'h00, 0);              // R7 empty ack, spurious 0xFF
      step(0, 0, 0, 0, 0, 1, 8'h0F, 32'hFFFF_F1F0);   // R9 mask to 9 bits, enable
      read_one(8'h0F);
      step(1, 8'h45, 0, 0, 0, 0, 8'h00, 0);           // R3 request rises
      step(1, 8'h31, 1, 0, 0, 0, 8'h00, 0);           // R4 level trigger bit
      step(0, 0, 0, 1, 0, 0, 8'h00, 0);               // R5 takes 0x45
      read_all();                                     // R2 ppr 0x40
      step(0, 0, 0, 0, 0, 1, 8'h08, 32'h50);          // TPR 0x50
      step(0, 0, 0, 1, 0, 0, 8'h00, 0);               // R6 blocked
      step(0, 0, 0, 0, 1, 1, 8'h21, 32'hFFFF_FFFF);   // R8 eoi, R10 ignored write
      read_all();
      step(0, 0, 0, 0, 0, 1, 8'h08, 32'h0);
      step(1, 8'hFF, 0, 1, 0, 0, 8'h00, 0);           // R4 set during ack
      step(1, 8'h00, 1, 1, 1, 0, 8'h00, 0);           // vector 0, overlapping strobes
      step(0, 0, 0, 0, 1, 0, 8'h00, 0);
      step(0, 0, 0, 0, 1, 0, 8'h00, 0);
      step(0, 0, 0, 0, 1, 0, 8'h00, 0);               // R8 eoi with empty service
      read_all();
      // constrained random
      for (int n = 0; n < 4000; n++) begin
         logic sv, ak, eo, we;
         logic [7:0] vec, addr;
         logic [31:0] wd;
         sv  = ($urandom_range(0, 99) < 40);
         vec = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(8'h28, 8'h58)) : 8'($urandom);
         ak  = ($urandom_range(0, 99) < 22);
         eo  = ($urandom_range(0, 99) < 20);
         we  = ($urandom_range(0, 99) < 8);
         case ($urandom_range(0, 3))
            0: addr = 8'h08;
            1: addr = 8'h0F;
            2: addr = 8'(8'h10 + $urandom_range(0, 23));
            default: addr = 8'h08;
         endcase
         wd = $urandom;
         if (addr == 8'h08 && $urandom_range(0, 1) == 0) wd = 32'd0;
         if (addr == 8'h0F) wd[8] = ($urandom_range(0, 99) < 85);
         step(sv, vec, $urandom_range(0, 1) == 1, ak, eo, we, addr, wd);
         if (n % 50 == 49) read_all();
      end
      idle();
      read_all();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog R11 actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule